// File: doc/BRIEF.md
# Strip-Mining Loop Sequencer

This block turns one long element-wise loop into a run of strips that a vector datapath can each finish in one pass. A job is given by a total element count and the base byte addresses of two source arrays and one destination array. From these the sequencer builds a series of strip descriptors. Each descriptor carries a strip length of at most the maximum vector length, together with the current address of each array. The descriptors go out one at a time over a valid/ready handshake.

The odd-sized piece comes first. The first strip carries the count modulo the maximum vector length, and every later strip is full length. After each accepted strip, each pointer advances by the strip length times the element size, and that length is taken off the remaining count. When nothing is left, a one-cycle done pulse is raised. The sequencer then accepts a new start.

Top module: `strip_seq`

## Requirements
- R1: After reset, strip_valid_o and done_o are both low.
- R2: For a start with count N that is not a multiple of 64, the first strip has length N mod 64, and its three addresses equal the base inputs captured at start.
- R3: For a nonzero N that is an exact multiple of 64, no zero-length strip is issued. The first strip already has length 64.
- R4: Every strip after the first has length 64, and no strip ever has length 0 or more than 64.
- R5: After each accepted strip (valid and ready high at a rising edge), each of the three addresses grows by the strip length times 8, modulo 2^32.
- R6: A job with count N issues exactly ceil(N/64) strips. done_o is high for exactly the one cycle after the last accepted strip, and strip_valid_o is low in that cycle.
- R7: A start with N = 0 issues no strip. done_o is high in the cycle after the start.
- R8: While strip_valid_o is high and strip_ready_i is low, the strip length and the three addresses do not change and valid stays high.
- R9: A start that arrives while a strip is pending is ignored, and the job in progress is unaffected.
- R10: A start presented in the cycle that done_o is high is accepted. Its first strip appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job; taken only while idle |
| count_i | input | 32 | Total element count of the job |
| src_a_i | input | 32 | Base byte address of first source array |
| src_b_i | input | 32 | Base byte address of second source array |
| dst_i | input | 32 | Base byte address of destination array |
| strip_ready_i | input | 1 | Consumer accepts the current strip |
| strip_valid_o | output | 1 | A strip descriptor is pending |
| strip_len_o | output | 7 | Element count of the current strip (1..64) |
| addr_a_o | output | 32 | Current first-source address |
| addr_b_o | output | 32 | Current second-source address |
| addr_c_o | output | 32 | Current destination address |
| done_o | output | 1 | One-cycle pulse when a job completes |

## Verification
Two events can land in the same cycle: acceptance of the final strip and a new start. One case drives start while a strip is still pending. The test checks that the descriptor holds and that only the strips of the original job come out. The other case drives start in the very cycle that done pulses. The test checks that the new job's first strip, with its remainder length and fresh bases, shows up one cycle later. The bench also varies the consumer's ready pattern and checks each descriptor against lengths and addresses it computes itself.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
    localparam int NPTR  = 3;
    localparam int PTR_A = 0;
    localparam int PTR_B = 1;
    localparam int PTR_C = 2;
endpackage

// File: rtl/seq_first_len.sv
module seq_first_len #(
    parameter int MVL = 64
) (
    input  logic [$clog2(MVL)-1:0] count_lsb_i,
    output logic [$clog2(MVL):0]   len_o
);
    localparam int LOG   = $clog2(MVL);
    localparam int LEN_W = LOG + 1;

    // a zero remainder means the leading strip would be empty: issue a full one
    always_comb begin
        if (count_lsb_i == '0) len_o = LEN_W'(MVL);
        else                   len_o = {1'b0, count_lsb_i};
    end
endmodule

// File: rtl/seq_ptr_adv.sv
module seq_ptr_adv #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 7,
    parameter int ELEM_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam int SHIFT = $clog2(ELEM_BYTES);

    always_comb next_o = base_i + (ADDR_W'(len_i) << SHIFT);
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 32,
    parameter int MVL        = 64,
    parameter int ELEM_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [CNT_W-1:0]       count_i,
    input  logic [ADDR_W-1:0]      src_a_i,
    input  logic [ADDR_W-1:0]      src_b_i,
    input  logic [ADDR_W-1:0]      dst_i,
    input  logic                   strip_ready_i,
    output logic                   strip_valid_o,
    output logic [$clog2(MVL):0]   strip_len_o,
    output logic [ADDR_W-1:0]      addr_a_o,
    output logic [ADDR_W-1:0]      addr_b_o,
    output logic [ADDR_W-1:0]      addr_c_o,
    output logic                   done_o
);
    import strip_seq_pkg::*;

    localparam int LOG   = $clog2(MVL);
    localparam int LEN_W = LOG + 1;

    typedef struct packed {
        logic                         busy;
        logic                         done;
        logic [CNT_W-1:0]             rem;
        logic [LEN_W-1:0]             len;
        logic [NPTR-1:0][ADDR_W-1:0]  ptr;
    } seq_state_t;

    seq_state_t                   st_d, st_q;
    logic [LEN_W-1:0]             first_len;
    logic [NPTR-1:0][ADDR_W-1:0]  ptr_nxt;
    logic [NPTR-1:0][ADDR_W-1:0]  ptr_base;

    assign ptr_base[PTR_A] = src_a_i;
    assign ptr_base[PTR_B] = src_b_i;
    assign ptr_base[PTR_C] = dst_i;

    seq_first_len #(.MVL(MVL)) u_first (
        .count_lsb_i (count_i[LOG-1:0]),
        .len_o       (first_len)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_adv
        seq_ptr_adv #(
            .ADDR_W     (ADDR_W),
            .LEN_W      (LEN_W),
            .ELEM_BYTES (ELEM_BYTES)
        ) u_adv (
            .base_i (st_q.ptr[g]),
            .len_i  (st_q.len),
            .next_o (ptr_nxt[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (count_i == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.rem  = count_i;
                    st_d.len  = first_len;
                    st_d.ptr  = ptr_base;
                end
            end
        end else if (strip_ready_i) begin
            st_d.ptr = ptr_nxt;
            st_d.rem = st_q.rem - CNT_W'(st_q.len);
            st_d.len = LEN_W'(MVL);
            if (st_q.rem == CNT_W'(st_q.len)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strip_valid_o = st_q.busy;
    assign strip_len_o   = st_q.len;
    assign addr_a_o      = st_q.ptr[PTR_A];
    assign addr_b_o      = st_q.ptr[PTR_B];
    assign addr_c_o      = st_q.ptr[PTR_C];
    assign done_o        = st_q.done;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 32,
    parameter int MVL        = 64,
    parameter int ELEM_BYTES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [CNT_W-1:0]     count_i,
    input logic                 strip_ready_i,
    input logic                 strip_valid_o,
    input logic [$clog2(MVL):0] strip_len_o,
    input logic [ADDR_W-1:0]    addr_a_o,
    input logic [ADDR_W-1:0]    addr_b_o,
    input logic [ADDR_W-1:0]    addr_c_o,
    input logic                 done_o
);
    localparam int LEN_W = $clog2(MVL) + 1;
    localparam int SHIFT = $clog2(ELEM_BYTES);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid_o && !strip_ready_i |=> strip_valid_o && $stable(strip_len_o)
        && $stable(addr_a_o) && $stable(addr_b_o) && $stable(addr_c_o));

    // R4
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid_o |-> strip_len_o != '0 && strip_len_o <= LEN_W'(MVL));

    // R4
    full_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid_o && strip_ready_i |=> done_o || strip_len_o == LEN_W'(MVL));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid_o && strip_ready_i |=> done_o ||
        (addr_a_o == $past(addr_a_o) + (ADDR_W'($past(strip_len_o)) << SHIFT) &&
         addr_c_o == $past(addr_c_o) + (ADDR_W'($past(strip_len_o)) << SHIFT)));

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !strip_valid_o);

    // R7
    empty_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strip_valid_o && start_i && count_i == '0 |=> done_o && !strip_valid_o);
endmodule

bind strip_seq strip_seq_chk #(
    .CNT_W (CNT_W), .ADDR_W (ADDR_W), .MVL (MVL), .ELEM_BYTES (ELEM_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .count_i       (count_i),
    .strip_ready_i (strip_ready_i),
    .strip_valid_o (strip_valid_o),
    .strip_len_o   (strip_len_o),
    .addr_a_o      (addr_a_o),
    .addr_b_o      (addr_b_o),
    .addr_c_o      (addr_c_o),
    .done_o        (done_o)
);

// File: tb/strip_seq_bench.sv
`timescale 1ns/1ps
module strip_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] count_i = '0;
    logic [31:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
    logic        strip_ready_i = 1'b0;
    logic        strip_valid_o;
    logic [6:0]  strip_len_o;
    logic [31:0] addr_a_o, addr_b_o, addr_c_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    strip_seq u_strip_seq (
        .clk, .rst_n, .start_i, .count_i, .src_a_i, .src_b_i, .dst_i,
        .strip_ready_i, .strip_valid_o, .strip_len_o,
        .addr_a_o, .addr_b_o, .addr_c_o, .done_o
    );

    localparam int NVEC = 8;
    localparam int unsigned TBL_N [NVEC] = '{1, 63, 64, 65, 128, 200, 0, 640};
    localparam int unsigned TBL_P [NVEC] = '{0, 1, 2, 0, 1, 2, 0, 1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // caller sits at a falling edge
    task automatic start_job(input int unsigned n, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] c);
        start_i = 1'b1; count_i = n; src_a_i = a; src_b_i = b; dst_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // entered at the falling edge where the first strip is visible
    task automatic consume(input int unsigned n, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] c, input int pat);
        int unsigned strips = (n + 63) / 64;
        int unsigned k = 0;
        int unsigned cyc = 0;
        logic [31:0] ea = a, eb = b, ec = c;
        logic [6:0]  el = (n % 64 == 0) ? 7'd64 : 7'(n % 64);
        while (k < strips && cyc < 5000) begin
            strip_ready_i = ((cyc % (pat + 1)) == 0);
            if (!strip_valid_o) begin
                check("R6 valid during job", 32'(strip_valid_o), 32'd1);
            end else if (strip_ready_i) begin
                // R2 R3 first strip, R4 later strips, R5 addresses
                check(k == 0 ? "R2/R3 len" : "R4 len", 32'(strip_len_o), 32'(el));
                check("R5 addr_a", addr_a_o, ea);
                check("R5 addr_b", addr_b_o, eb);
                check("R5 addr_c", addr_c_o, ec);
                ea += 32'(el) * 8; eb += 32'(el) * 8; ec += 32'(el) * 8;
                el = 7'd64;
                k++;
            end else begin
                // R8 held descriptor
                check("R8 hold len", 32'(strip_len_o), 32'(el));
                check("R8 hold addr_c", addr_c_o, ec);
            end
            cyc++;
            @(negedge clk);
        end
        strip_ready_i = 1'b0;
        // R6 and R7: done exactly here, no strip pending
        check(n == 0 ? "R7 done" : "R6 done", 32'(done_o), 32'd1);
        check("R6 valid low at done", 32'(strip_valid_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(strip_valid_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] a = 32'h1000_0000 + 32'(i) * 32'h100;
            logic [31:0] b = 32'h2000_0000 + 32'(i) * 32'h100;
            logic [31:0] c = 32'hFFFF_FF00 + 32'(i) * 8;
            start_job(TBL_N[i], a, b, c);
            consume(TBL_N[i], a, b, c, int'(TBL_P[i]));
            @(negedge clk);
            check("R6 done single", 32'(done_o), 32'd0);
        end

        // R9: start while a strip is pending
        start_job(130, 32'h4000, 32'h5000, 32'h6000);
        start_i = 1'b1; count_i = 5; src_a_i = 32'h9; strip_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 len kept", 32'(strip_len_o), 32'd2);
        check("R9 addr kept", addr_a_o, 32'h4000);
        consume(130, 32'h4000, 32'h5000, 32'h6000, 0);

        // R10: start in the done cycle
        start_job(70, 32'h100, 32'h200, 32'h300);
        check("R10 valid", 32'(strip_valid_o), 32'd1);
        check("R10 len", 32'(strip_len_o), 32'd6);
        consume(70, 32'h100, 32'h200, 32'h300, 1);
        @(negedge clk);
        check("R9 no stray job", 32'(strip_valid_o), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule